// File: doc/BRIEF.md
# Precision-Aliased Floating-Point Register File

This block is the storage behind a floating-point unit whose registers can be addressed at three widths. A single physical array of 32-bit words is seen through three overlapping views: 32-bit singles, 64-bit doubles built from two adjacent singles, and 128-bit quads built from two adjacent doubles. A second bank of words extends the double and quad views only, so it can never be named as a single. All three views reach the same bits, and writing through one view changes what the other two read.

There is one read port and one write port. Each port takes a 5-bit register specifier and a 2-bit precision code, and moves data on a 128-bit bus with the value right-aligned. For doubles and quads, bit 0 of the specifier chooses the bank. A quad specifier that does not land on a four-word boundary, or the reserved precision code, is flagged as misaligned. Such a write is dropped and such a read returns zero. Reads are registered and take the contents from before any write made in the same cycle.

Top module: `fp_alias_regfile`

## Requirements
- R1: While reset (`rst_n` low at a clock edge) is applied, every storage word is cleared and `rd_data`/`rd_misalign` are cleared. After reset, every register at every precision reads zero.
- R2: The precision code 2'b00 selects a single. Single specifier s names lower-bank word s. A read returns that word on `rd_data[31:0]` with bits 127:32 zero. A write stores `wr_data[31:0]`.
- R3: The precision code 2'b01 selects a double. A double specifier d with d[0]=0 covers lower words d and d+1. Word d is on bits 63:32, word d+1 is on bits 31:0, and bits 127:64 read zero.
- R4: The precision code 2'b10 selects a quad. A quad specifier q with q[1:0]=2'b00 covers lower words q..q+3. Word q is on bits 127:96 and word q+3 is on bits 31:0.
- R5: A double or quad specifier with bit 0 set selects the upper bank. Upper word index is 2*(spec>>1), double upper number is spec>>1, and a quad over the upper bank spans two upper doubles. No single specifier reaches the upper bank, and upper-bank writes leave every single unchanged.
- R6: A single write changes only its own 32-bit word. The other half of the containing double keeps its value.
- R7: A quad specifier with bit 1 set, or precision code 2'b11, is misaligned. For the write port, `wr_misalign` is raised in the same cycle and the write changes no storage. For the read port, `rd_misalign` is raised and `rd_data` is zero. Double specifiers are never misaligned.
- R8: The `rd_data` and `rd_misalign` outputs reflect the read request one clock edge earlier. A write in the same cycle to overlapping words is not visible until the following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_spec | input | 5 | Write register specifier |
| wr_prec | input | 2 | Write precision code (00 single, 01 double, 10 quad, 11 reserved) |
| wr_data | input | 128 | Write value, right-aligned |
| wr_misalign | output | 1 | Current write specifier is misaligned or precision reserved |
| rd_spec | input | 5 | Read register specifier |
| rd_prec | input | 2 | Read precision code |
| rd_data | output | 128 | Read value, right-aligned, one cycle after the request |
| rd_misalign | output | 1 | Previous read request was misaligned or reserved |

## Verification
The assertions assume that the port inputs are known, two-state values at every clock edge once reset is released. They also assume that the precision code and specifier held during a cycle describe the request that the registered outputs answer one edge later. The bench drives every input at the falling edge, away from the sampling edge, and holds it for the whole cycle. Its stimulus takes all four precision codes and the full specifier range, including the reserved code and misaligned quads. It writes and reads the same locations in the same cycle to exercise the read-first ordering.

// File: rtl/fpa_pkg.sv
// Shared types and sizing for the precision-aliased register file.
// Assumes a power-of-two lane count so that base|lane addressing is exact.
package fpa_pkg;

    localparam int WORD_W  = 32;
    localparam int SPEC_W  = 5;
    localparam int LANES   = 4;
    localparam int DATA_W  = WORD_W * LANES;
    localparam int IDX_W   = SPEC_W + 1;

    typedef enum logic [1:0] {
        PREC_SGL  = 2'b00,
        PREC_DBL  = 2'b01,
        PREC_QUAD = 2'b10,
        PREC_RSV  = 2'b11
    } prec_e;

    // Number of 32-bit lanes a precision occupies (0 for reserved).
    function automatic int lanes_of(input logic [1:0] prec);
        case (prec)
            PREC_SGL:  return 1;
            PREC_DBL:  return 2;
            PREC_QUAD: return 4;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/fpa_decode.sv
// Specifier decoder: turns a 5-bit specifier and precision code into the
// first storage word index, a per-lane enable and a misalignment flag.
// Assumes doubles/quads take bit 0 as the bank select (upper index half).
module fpa_decode
    import fpa_pkg::*;
#(
    parameter int SPEC_BITS = SPEC_W,
    parameter int NLANES    = LANES,
    localparam int IDXB     = SPEC_BITS + 1
) (
    input  logic [SPEC_BITS-1:0] spec,
    input  logic [1:0]           prec,
    output logic [IDXB-1:0]      base,
    output logic [NLANES-1:0]    lane_en,
    output logic                 misalign
);

    logic [IDXB-1:0] wide_base;

    // Word index of a double/quad: bank bit on top, pair number below.
    always_comb wide_base = {spec[0], spec[SPEC_BITS-1:1], 1'b0};

    // Choose the base, lane enables and alignment status per precision.
    always_comb begin
        base     = '0;
        lane_en  = '0;
        misalign = 1'b0;
        case (prec)
            PREC_SGL: begin
                base       = {1'b0, spec};
                lane_en[0] = 1'b1;
            end
            PREC_DBL: begin
                base          = wide_base;
                lane_en[1:0]  = 2'b11;
            end
            PREC_QUAD: begin
                base     = wide_base;
                misalign = spec[1];
                lane_en  = spec[1] ? '0 : '1;
            end
            default: begin
                misalign = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fpa_lane_pack.sv
// Write-side formatter: splits a right-aligned value into storage lanes,
// lane 0 carrying the most significant word of the value (big-endian order).
// Assumes the precision code is valid when any lane enable is set.
module fpa_lane_pack
    import fpa_pkg::*;
#(
    parameter int WBITS  = WORD_W,
    parameter int NLANES = LANES,
    localparam int DBITS = WBITS * NLANES
) (
    input  logic [1:0]       prec,
    input  logic [DBITS-1:0] data,
    output logic [WBITS-1:0] lane_word [NLANES]
);

    // Place each word of the value onto its lane, lowest lane = top word.
    always_comb begin
        int n;
        n = lanes_of(prec);
        for (int k = 0; k < NLANES; k++) begin
            lane_word[k] = '0;
            if (k < n) begin
                lane_word[k] = data[WBITS*(n-1-k) +: WBITS];
            end
        end
    end

endmodule

// File: rtl/fpa_lane_unpack.sv
// Read-side formatter: assembles storage lanes into a right-aligned value,
// zeroing unused upper bits and the whole value on a misaligned request.
// Assumes prec and misalign are aligned in time with the lane words.
module fpa_lane_unpack
    import fpa_pkg::*;
#(
    parameter int WBITS  = WORD_W,
    parameter int NLANES = LANES,
    localparam int DBITS = WBITS * NLANES
) (
    input  logic [1:0]       prec,
    input  logic             misalign,
    input  logic [WBITS-1:0] lane_word [NLANES],
    output logic [DBITS-1:0] data
);

    // Build the output value from the lanes that the precision covers.
    always_comb begin
        int n;
        n    = lanes_of(prec);
        data = '0;
        if (!misalign) begin
            for (int k = 0; k < NLANES; k++) begin
                if (k < n) begin
                    data[WBITS*(n-1-k) +: WBITS] = lane_word[k];
                end
            end
        end
    end

endmodule

// File: rtl/fpa_store.sv
// Word array for both banks with lane-addressed write and registered read.
// Assumes base indices are aligned to their lane count, so base|lane never
// carries and lanes of one access never collide on the same word.
module fpa_store #(
    parameter int WBITS  = 32,
    parameter int IDXB   = 6,
    parameter int NLANES = 4,
    localparam int NWORDS = 1 << IDXB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLANES-1:0] wr_lane_en,
    input  logic [IDXB-1:0]   wr_base,
    input  logic [WBITS-1:0]  wr_word [NLANES],
    input  logic [IDXB-1:0]   rd_base,
    output logic [WBITS-1:0]  rd_word [NLANES]
);

    logic [WBITS-1:0] word_view [NWORDS];

    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
        logic [NLANES-1:0] hit;
        logic [WBITS-1:0]  nxt;
        logic [WBITS-1:0]  q;

        for (genvar gk = 0; gk < NLANES; gk++) begin : g_hit
            assign hit[gk] = wr_lane_en[gk] &&
                             ((wr_base | IDXB'(gk)) == IDXB'(gi));
        end

        // Select the lane value aimed at this word.
        always_comb begin
            nxt = q;
            for (int k = 0; k < NLANES; k++) begin
                if (hit[k]) nxt = wr_word[k];
            end
        end

        // Hold the word; clear it in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= nxt;
        end

        assign word_view[gi] = q;
    end

    // Capture the addressed words before this edge's write lands.
    always_ff @(posedge clk) begin
        for (int k = 0; k < NLANES; k++) begin
            if (!rst_n) rd_word[k] <= '0;
            else        rd_word[k] <= word_view[rd_base | IDXB'(k)];
        end
    end

endmodule

// File: rtl/fp_alias_regfile.sv
// Floating-point register file with single/double/quad views aliasing one
// word array; the upper bank is reachable only as doubles or quads.
// One write port and one registered read-first read port, 128-bit
// right-aligned data. Assumes inputs are stable around the rising edge.
module fp_alias_regfile
    import fpa_pkg::*;
#(
    parameter int WBITS  = WORD_W,
    parameter int SBITS  = SPEC_W,
    parameter int NLANES = LANES,
    localparam int DBITS = WBITS * NLANES,
    localparam int IDXB  = SBITS + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SBITS-1:0] wr_spec,
    input  logic [1:0]       wr_prec,
    input  logic [DBITS-1:0] wr_data,
    output logic             wr_misalign,
    input  logic [SBITS-1:0] rd_spec,
    input  logic [1:0]       rd_prec,
    output logic [DBITS-1:0] rd_data,
    output logic             rd_misalign
);

    logic [IDXB-1:0]   w_base, r_base;
    logic [NLANES-1:0] w_lanes, r_lanes;
    logic              w_mis, r_mis;
    logic [NLANES-1:0] w_lane_en;
    logic [WBITS-1:0]  w_word [NLANES];
    logic [WBITS-1:0]  r_word [NLANES];
    logic [1:0]        rd_prec_q;
    logic              rd_mis_q;

    fpa_decode #(.SPEC_BITS(SBITS), .NLANES(NLANES)) u_wdec (
        .spec(wr_spec), .prec(wr_prec),
        .base(w_base), .lane_en(w_lanes), .misalign(w_mis)
    );

    fpa_decode #(.SPEC_BITS(SBITS), .NLANES(NLANES)) u_rdec (
        .spec(rd_spec), .prec(rd_prec),
        .base(r_base), .lane_en(r_lanes), .misalign(r_mis)
    );

    // Gate the write lanes with the request; misaligned writes have none.
    always_comb w_lane_en = wr_en ? w_lanes : '0;

    fpa_lane_pack #(.WBITS(WBITS), .NLANES(NLANES)) u_pack (
        .prec(wr_prec), .data(wr_data), .lane_word(w_word)
    );

    fpa_store #(.WBITS(WBITS), .IDXB(IDXB), .NLANES(NLANES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_lane_en(w_lane_en), .wr_base(w_base), .wr_word(w_word),
        .rd_base(r_base), .rd_word(r_word)
    );

    // Carry the read's precision and status alongside the registered words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_prec_q <= PREC_SGL;
            rd_mis_q  <= 1'b0;
        end else begin
            rd_prec_q <= rd_prec;
            rd_mis_q  <= r_mis || (r_lanes == '0);
        end
    end

    fpa_lane_unpack #(.WBITS(WBITS), .NLANES(NLANES)) u_unpack (
        .prec(rd_prec_q), .misalign(rd_mis_q),
        .lane_word(r_word), .data(rd_data)
    );

    assign wr_misalign = w_mis;
    assign rd_misalign = rd_mis_q;

endmodule

// File: rtl/fp_alias_regfile_chk.sv
// Property checker for fp_alias_regfile, attached by bind. Observes ports
// only and assumes two-state inputs held across each rising edge.
module fp_alias_regfile_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [4:0]   wr_spec,
    input logic [1:0]   wr_prec,
    input logic         wr_misalign,
    input logic [4:0]   rd_spec,
    input logic [1:0]   rd_prec,
    input logic [127:0] rd_data,
    input logic         rd_misalign
);

    // R7: a misaligned read answers with zero data.
    a_r7_mis_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_misalign |-> rd_data == '0);

    // R2: a single read leaves bits above 31 clear.
    a_r2_single_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_prec == 2'b00) |=> rd_data[127:32] == '0);

    // R3: a double read leaves bits above 63 clear.
    a_r3_double_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_prec == 2'b01) |=> rd_data[127:64] == '0);

    // R7: singles, doubles and aligned quads are never flagged on read.
    a_r7_aligned_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_prec == 2'b00 || rd_prec == 2'b01 ||
         (rd_prec == 2'b10 && !rd_spec[1])) |=> !rd_misalign);

    // R7: the reserved code always flags on read.
    a_r7_reserved_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_prec == 2'b11) |=> rd_misalign);

    // R7: the write-side flag never rises for singles or doubles.
    a_r7_wr_flag_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_prec == 2'b00 || wr_prec == 2'b01) |-> !wr_misalign);

endmodule

bind fp_alias_regfile fp_alias_regfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_spec(wr_spec),
    .wr_prec(wr_prec), .wr_misalign(wr_misalign), .rd_spec(rd_spec),
    .rd_prec(rd_prec), .rd_data(rd_data), .rd_misalign(rd_misalign)
);

// File: tb/fp_alias_regfile_tb.sv
// Self-checking bench with a behavioural word-array model compared every cycle.
module fp_alias_regfile_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_spec = '0;
    logic [1:0]   wr_prec = '0;
    logic [127:0] wr_data = '0;
    logic         wr_misalign;
    logic [4:0]   rd_spec = '0;
    logic [1:0]   rd_prec = '0;
    logic [127:0] rd_data;
    logic         rd_misalign;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mdl [64];

    always #5 clk = ~clk;

    fp_alias_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_spec(wr_spec),
        .wr_prec(wr_prec), .wr_data(wr_data), .wr_misalign(wr_misalign),
        .rd_spec(rd_spec), .rd_prec(rd_prec), .rd_data(rd_data),
        .rd_misalign(rd_misalign)
    );

    function automatic int width_of(int prec);
        if (prec == 0) return 1;
        if (prec == 1) return 2;
        if (prec == 2) return 4;
        return 0;
    endfunction

    function automatic int first_word(int spec, int prec);
        if (prec == 0) return spec;
        return (spec % 2) * 32 + (spec / 2) * 2;
    endfunction

    function automatic bit is_mis(int spec, int prec);
        return (prec == 3) || (prec == 2 && ((spec / 2) % 2) == 1);
    endfunction

    function automatic logic [127:0] model_read(int spec, int prec);
        logic [127:0] v = '0;
        int n = width_of(prec);
        int b = first_word(spec, prec);
        if (is_mis(spec, prec)) return '0;
        for (int k = 0; k < n; k++) v[32*(n-1-k) +: 32] = mdl[b+k];
        return v;
    endfunction

    task automatic chk(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Called at a falling edge: drive one cycle, check, then update the model.
    task automatic step(bit we, int ws, int wp, logic [127:0] wd,
                        int rs, int rp, string tag);
        logic [127:0] exp_d;
        bit exp_m;
        bit wmis;
        int n;
        int b;
        wr_en = we; wr_spec = 5'(ws); wr_prec = 2'(wp); wr_data = wd;
        rd_spec = 5'(rs); rd_prec = 2'(rp);
        #1;
        wmis = is_mis(ws, wp);
        chk(wr_misalign == wmis, {tag, " R7 wr_misalign"},
            128'(wr_misalign), 128'(wmis));
        exp_d = model_read(rs, rp);
        exp_m = is_mis(rs, rp);
        @(posedge clk);
        @(negedge clk);
        chk(rd_data == exp_d, {tag, " R8 rd_data"}, rd_data, exp_d);
        chk(rd_misalign == exp_m, {tag, " R7 rd_misalign"},
            128'(rd_misalign), 128'(exp_m));
        if (we && !wmis) begin
            n = width_of(wp);
            b = first_word(ws, wp);
            for (int k = 0; k < n; k++) mdl[b+k] = wd[32*(n-1-k) +: 32];
        end
    endtask

    task automatic rd(int rs, int rp, string tag);
        step(1'b0, 0, 0, '0, rs, rp, tag);
    endtask

    task automatic wr(int ws, int wp, logic [127:0] wd, string tag);
        step(1'b1, ws, wp, wd, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(rd_data == '0, "R1 rd_data after reset", rd_data, '0);
        chk(rd_misalign == 1'b0, "R1 rd_misalign after reset",
            128'(rd_misalign), '0);
        // R1: all doubles in both banks read zero.
        for (int s = 0; s < 32; s++) rd(s, 1, "R1 double after reset");
        for (int s = 0; s < 32; s++) rd(s, 0, "R1 single after reset");

        // R2: single write and readback.
        wr(3, 0, 128'hFFFF_0000_1111_2222_3333_4444_A5A5_0003, "R2 wr single 3");
        rd(3, 0, "R2 rd single 3");
        rd(2, 1, "R3 rd double holding single 3");

        // R3: double covering words 4,5.
        wr(4, 1, 128'h0_0000_0000_0000_1234_5678_9ABC_DEF0, "R3 wr double 4");
        rd(4, 0, "R3 single 4 = high half");
        rd(5, 0, "R3 single 5 = low half");
        rd(4, 1, "R3 rd double 4");

        // R4: quad covering words 8..11.
        wr(8, 2, 128'h0808_0808_0909_0909_0A0A_0A0A_0B0B_0B0B, "R4 wr quad 8");
        rd(8, 0, "R4 single 8");
        rd(11, 0, "R4 single 11");
        rd(10, 1, "R4 double 10");
        rd(8, 2, "R4 rd quad 8");

        // R5: upper bank through double spec 1 and quad spec 1.
        wr(1, 1, 128'h0_0000_0000_0000_C0DE_0001_C0DE_0002, "R5 wr upper double 1");
        wr(3, 1, 128'h0_0000_0000_0000_C0DE_0003_C0DE_0004, "R5 wr upper double 3");
        rd(1, 0, "R5 single 1 untouched by upper write");
        rd(0, 1, "R5 lower double 0 untouched");
        rd(1, 2, "R5 rd upper quad 1");
        rd(31, 1, "R5 rd upper double 31");

        // R6: single write touches only its slice.
        wr(9, 0, 128'h0_0000_0000_0000_0000_0000_5555_AAAA, "R6 wr single 9");
        rd(8, 1, "R6 double 8 keeps word 8");

        // R7: misaligned quad and reserved code.
        wr(2, 2, 128'hDEAD_DEAD_DEAD_DEAD_DEAD_DEAD_DEAD_DEAD, "R7 wr mis quad 2");
        rd(0, 2, "R7 quad 0 unchanged");
        rd(2, 2, "R7 rd mis quad 2");
        wr(8, 3, 128'hBEEF_BEEF_BEEF_BEEF_BEEF_BEEF_BEEF_BEEF, "R7 wr reserved");
        rd(8, 2, "R7 quad 8 unchanged after reserved write");
        rd(8, 3, "R7 rd reserved");

        // R8: same-cycle write and read of the same location.
        step(1'b1, 12, 2, 128'h1111_2222_3333_4444_5555_6666_7777_8888,
             12, 2, "R8 read-first quad 12");
        rd(12, 2, "R8 new quad 12 visible next");
        step(1'b1, 13, 0, 128'h0000_0000_0000_0000_0000_0000_0000_9999,
             12, 1, "R8 read-first single inside double");
        rd(12, 1, "R8 double 12 after single write");

        // Mixed traffic over the full specifier and precision ranges.
        for (int i = 0; i < 3000; i++) begin
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, 31)),
                 int'($urandom_range(0, 3)),
                 {$urandom, $urandom, $urandom, $urandom},
                 int'($urandom_range(0, 31)), int'($urandom_range(0, 3)),
                 "R2 R3 R4 R5 mixed");
        end
        finish_run();
    end

endmodule